// File: doc/BRIEF.md
# Video Line Lock Detector with Reference Select

This block sits beside a horizontal line-rate phase-locked loop. It decides whether the loop is locked to incoming video, and it chooses which sync source drives the phase detector's reference input. It has three synchronous inputs: a composite sync pulse taken from the video, the horizontal sync made by the local line counter, and the feedback pulse from the loop divider. For every line it compares the rising edge of the chosen reference with the rising edge of the feedback pulse. A line counts as in phase when the two edges are no more than a programmable number of clock cycles apart, in either order.

The lock decision uses hysteresis. Declaring lock takes a long run of consecutive in-phase lines. Declaring loss of lock takes only a short run of consecutive out-of-phase lines. The lock flag is active low. While the loop is unlocked, composite sync is the reference, because it is present whether or not the loop has converged. Once the loop is locked, the reference moves to the internal sync, so that the equalizing and serration pulses in composite sync cannot disturb a loop that has settled.

The reference multiplexer changes its selection only on a cycle where both sync inputs are low, so the phase detector never sees a clipped or doubled pulse. None of the pins is a data stream, so the block has no valid/ready handshake. All pins are plain level signals, sampled on every clock.

Top module: `line_lock_detect`

## Requirements
- R1: After reset the lock flag `lock_n_o` is high and both line counters are cleared. Composite sync is the selected reference, so `ref_o` follows `csync_i`.
- R2: While unlocked, `ref_o` follows `csync_i`. While locked, it follows `hsync_int_i`, once the first line boundary after the change of lock state has passed.
- R3: Lock is declared on the in-phase line that completes `LOCK_LINES` (default 15) consecutive in-phase lines, and not one line earlier.
- R4: Loss of lock is declared on the out-of-phase line that completes `UNLOCK_LINES` (default 3) consecutive out-of-phase lines, and not one line earlier.
- R5: A line is in phase when the feedback rising edge is no more than `WIN_CLKS` cycles before or after the reference rising edge; same-cycle edges also count. An offset of `WIN_CLKS`+1 cycles in either direction makes the line out of phase.
- R6: An out-of-phase line clears the lock-run counter, and an in-phase line clears the unlock-run counter, so both runs must be unbroken.
- R7: The reference selection changes only in the cycle after a cycle in which `csync_i` and `hsync_int_i` are both low. An internal sync pulse that is already in progress when lock is declared never reaches `ref_o`.
- R8: If no reference rising edge arrives for `LINE_CLKS + LINE_CLKS/2` cycles, that interval counts as one out-of-phase line, and the timer restarts.
- R9: `lock_n_o` is low exactly while the block considers the loop locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_i | input | 1 | Composite sync separated from the video, active high |
| hsync_int_i | input | 1 | Horizontal sync from the local line counter, active high |
| fb_i | input | 1 | Feedback pulse from the loop divider, active high |
| ref_o | output | 1 | Selected reference pulse to the phase detector |
| lock_n_o | output | 1 | Lock flag, low while locked |

## Verification
The in-phase case is driven with feedback offsets that sweep every value from minus to plus the window. The out-of-phase case uses offsets one cycle past the window on either side, which separates a correct window from one that is off by one. Runs of in-phase lines broken by a single bad line, and runs of bad lines broken by a single good line, show whether the counters reset or merely pause. Lines with no sync at all exercise the missing-edge timer, and a lock-completing line whose internal sync pulse outlasts composite sync shows whether the multiplexer waits for a line boundary.

// File: rtl/llk_pkg.sv
package llk_pkg;
  typedef enum logic [1:0] {
    VERD_NONE = 2'd0,
    VERD_IN   = 2'd1,
    VERD_OUT  = 2'd2
  } verdict_e;
endpackage

// File: rtl/llk_rise_det.sv
module llk_rise_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign rise_o[i] = sig_i[i] & ~prev_q[i];
  end
endmodule

// File: rtl/llk_ref_mux.sv
module llk_ref_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic hs_i,
  input  logic want_int_i,
  output logic ref_o
);
  logic sel_q;
  logic idle;

  assign idle = ~cs_i & ~hs_i;

  // Selection moves only across a quiet gap between pulses.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_q <= 1'b0;
    else if (idle) sel_q <= want_int_i;
  end

  assign ref_o = sel_q ? hs_i : cs_i;

  p_switch_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> $past(!cs_i && !hs_i));
endmodule

// File: rtl/llk_phase_win.sv
module llk_phase_win
  import llk_pkg::*;
#(
  parameter int WIN_CLKS = 4,
  parameter int TMO_CLKS = 1287
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ref_rise_i,
  input  logic     fb_rise_i,
  output verdict_e verdict_o
);
  localparam int FB_W  = $clog2(WIN_CLKS + 2);
  localparam int PC_W  = $clog2(WIN_CLKS + 1);
  localparam int AGE_W = $clog2(TMO_CLKS + 1);
  localparam logic [FB_W-1:0]  FB_SAT = FB_W'(WIN_CLKS + 1);
  localparam logic [FB_W-1:0]  FB_WIN = FB_W'(WIN_CLKS);
  localparam logic [PC_W-1:0]  PC_WIN = PC_W'(WIN_CLKS);
  localparam logic [AGE_W-1:0] AGE_TMO = AGE_W'(TMO_CLKS);

  logic [FB_W-1:0]  fb_age_q;
  logic             pend_q, pend_d;
  logic [PC_W-1:0]  pcnt_q, pcnt_d;
  logic [AGE_W-1:0] age_q, age_d;
  logic             fb_near;
  verdict_e         verd;

  // Cycles since the last feedback edge, saturating just past the window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               fb_age_q <= FB_SAT;
    else if (fb_rise_i)       fb_age_q <= FB_W'(1);
    else if (fb_age_q < FB_SAT) fb_age_q <= fb_age_q + 1'b1;
  end

  assign fb_near = fb_rise_i | (fb_age_q <= FB_WIN);

  always_comb begin
    verd   = VERD_NONE;
    pend_d = pend_q;
    pcnt_d = pcnt_q;
    if (pend_q) begin
      if (fb_rise_i) begin
        verd   = VERD_IN;
        pend_d = 1'b0;
      end else if (pcnt_q == PC_WIN) begin
        verd   = VERD_OUT;
        pend_d = 1'b0;
      end else begin
        pcnt_d = pcnt_q + 1'b1;
      end
    end else if (ref_rise_i) begin
      if (fb_near) begin
        verd = VERD_IN;
      end else begin
        pend_d = 1'b1;
        pcnt_d = PC_W'(1);
      end
    end

    // Missing reference: one timeout interval is one bad line.
    if (ref_rise_i) begin
      age_d = AGE_W'(1);
    end else if (age_q == AGE_TMO) begin
      age_d = AGE_W'(1);
      if (verd == VERD_NONE) verd = VERD_OUT;
    end else begin
      age_d = age_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pcnt_q <= '0;
      age_q  <= AGE_W'(1);
    end else begin
      pend_q <= pend_d;
      pcnt_q <= pcnt_d;
      age_q  <= age_d;
    end
  end

  assign verdict_o = verd;

  p_pend_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (pcnt_q >= PC_W'(1)) && (pcnt_q <= PC_WIN));
  p_age_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= AGE_W'(1)) && (age_q <= AGE_TMO));
  p_tmo_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == AGE_TMO) |=> (age_q == AGE_W'(1)));
endmodule

// File: rtl/llk_lock_fsm.sv
module llk_lock_fsm
  import llk_pkg::*;
#(
  parameter int LOCK_LINES   = 15,
  parameter int UNLOCK_LINES = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  verdict_e verdict_i,
  output logic     locked_o
);
  localparam int GW = $clog2(LOCK_LINES + 1);
  localparam int BW = $clog2(UNLOCK_LINES + 1);
  localparam logic [GW-1:0] GOOD_LAST = GW'(LOCK_LINES - 1);
  localparam logic [BW-1:0] BAD_LAST  = BW'(UNLOCK_LINES - 1);

  logic          locked_q, locked_d;
  logic [GW-1:0] good_q, good_d;
  logic [BW-1:0] bad_q, bad_d;

  always_comb begin
    locked_d = locked_q;
    good_d   = good_q;
    bad_d    = bad_q;
    case (verdict_i)
      VERD_IN: begin
        bad_d = '0;
        if (!locked_q) begin
          if (good_q == GOOD_LAST) begin
            locked_d = 1'b1;
            good_d   = '0;
          end else begin
            good_d = good_q + 1'b1;
          end
        end
      end
      VERD_OUT: begin
        good_d = '0;
        if (locked_q) begin
          if (bad_q == BAD_LAST) begin
            locked_d = 1'b0;
            bad_d    = '0;
          end else begin
            bad_d = bad_q + 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      good_q   <= '0;
      bad_q    <= '0;
    end else begin
      locked_q <= locked_d;
      good_q   <= good_d;
      bad_q    <= bad_d;
    end
  end

  assign locked_o = locked_q;

  p_lock_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> ($past(good_q) == GOOD_LAST) && ($past(verdict_i) == VERD_IN));
  p_lock_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_q) |-> ($past(bad_q) == BAD_LAST) && ($past(verdict_i) == VERD_OUT));
  p_good_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_i == VERD_OUT) |=> (good_q == '0));
  p_bad_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_i == VERD_IN) |=> (bad_q == '0));
endmodule

// File: rtl/line_lock_detect.sv
module line_lock_detect
  import llk_pkg::*;
#(
  parameter int LINE_CLKS    = 858,
  parameter int WIN_CLKS     = 4,
  parameter int LOCK_LINES   = 15,
  parameter int UNLOCK_LINES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync_i,
  input  logic hsync_int_i,
  input  logic fb_i,
  output logic ref_o,
  output logic lock_n_o
);
  localparam int TMO_CLKS = LINE_CLKS + LINE_CLKS / 2;

  logic     ref_sel;
  logic     locked;
  logic     ref_rise, fb_rise;
  verdict_e verdict;

  llk_ref_mux u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_i       (csync_i),
    .hs_i       (hsync_int_i),
    .want_int_i (locked),
    .ref_o      (ref_sel)
  );

  llk_rise_det #(.N(2)) u_rise (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  ({ref_sel, fb_i}),
    .rise_o ({ref_rise, fb_rise})
  );

  llk_phase_win #(
    .WIN_CLKS (WIN_CLKS),
    .TMO_CLKS (TMO_CLKS)
  ) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_rise_i (ref_rise),
    .fb_rise_i  (fb_rise),
    .verdict_o  (verdict)
  );

  llk_lock_fsm #(
    .LOCK_LINES   (LOCK_LINES),
    .UNLOCK_LINES (UNLOCK_LINES)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .verdict_i (verdict),
    .locked_o  (locked)
  );

  assign ref_o    = ref_sel;
  assign lock_n_o = ~locked;

  p_flag_moves_on_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lock_n_o) |-> $past(verdict != VERD_NONE));
endmodule

// File: tb/sim_line_lock_detect.sv
`timescale 1ns/1ps
module sim_line_lock_detect;
  localparam int L  = 40;
  localparam int W  = 3;
  localparam int P  = 10;

  logic clk = 1'b0;
  logic rst_n, csync, hsync, fb;
  logic ref_o, lock_n;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;
  logic ra, rb;

  always #2.5 clk = ~clk;

  line_lock_detect #(
    .LINE_CLKS(L), .WIN_CLKS(W), .LOCK_LINES(15), .UNLOCK_LINES(3)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .csync_i(csync), .hsync_int_i(hsync),
    .fb_i(fb), .ref_o(ref_o), .lock_n_o(lock_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One line of L cycles; negative position means the pulse is absent.
  task automatic run_line(input int cs_p, input int hs_p, input int hs_w,
                          input int fb_p, input int sa, input int sb);
    for (int c = 0; c < L; c++) begin
      @(negedge clk);
      csync = (cs_p >= 0) && (c >= cs_p) && (c < cs_p + 3);
      hsync = (hs_p >= 0) && (c >= hs_p) && (c < hs_p + hs_w);
      fb    = (fb_p >= 0) && (c >= fb_p) && (c < fb_p + 2);
      #1;
      if (c == sa) ra = ref_o;
      if (c == sb) rb = ref_o;
    end
  endtask

  task automatic line_at(input int off);
    run_line(P, P, 3, P + off, -1, -1);
  endtask

  task automatic good_run(input int n);
    for (int i = 0; i < n; i++) line_at((i % (2 * W + 1)) - W);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; csync = 0; hsync = 0; fb = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 lock flag after reset", lock_n, 1);
    run_line(2, 20, 3, 20, 3, 21);
    chk("R1 ref follows csync pulse", ra, 1);
    chk("R2 internal sync blocked while unlocked", rb, 0);
  endtask

  task automatic t_lock_count;
    good_run(14);
    chk("R3 not locked after 14 lines", lock_n, 1);
    run_line(P, P, 9, P, 15, -1);
    chk("R7 open internal pulse not passed", ra, 0);
    chk("R3 R9 locked on line 15", lock_n, 0);
    run_line(2, 20, 3, 20, 3, 21);
    chk("R2 csync blocked while locked", ra, 0);
    chk("R2 internal sync passed while locked", rb, 1);
    chk("R2 lock held on probe line", lock_n, 0);
  endtask

  task automatic t_unlock;
    line_at(W + 1);
    line_at(-(W + 1));
    chk("R4 still locked after 2 bad lines", lock_n, 0);
    line_at(W + 1);
    chk("R4 R9 unlocked on bad line 3", lock_n, 1);
    run_line(2, 20, 3, 20, 3, 21);
    chk("R2 csync restored after unlock", ra, 1);
    chk("R2 internal sync blocked after unlock", rb, 0);
  endtask

  task automatic t_window_run;
    good_run(14);
    line_at(W + 1);
    line_at(0);
    chk("R5 R6 late edge broke the run", lock_n, 1);
    good_run(13);
    chk("R6 14 lines after break not enough", lock_n, 1);
    line_at(-W);
    chk("R5 R6 locked after fresh run of 15", lock_n, 0);
  endtask

  task automatic t_unlock_clear;
    line_at(W + 1);
    line_at(W + 1);
    line_at(0);
    line_at(-(W + 1));
    line_at(W + 1);
    chk("R6 good line cleared bad run", lock_n, 0);
    line_at(-(W + 1));
    chk("R6 R4 unlocked after 3 unbroken bad", lock_n, 1);
  endtask

  task automatic t_timeout;
    good_run(15);
    chk("R3 relock before timeout test", lock_n, 0);
    for (int i = 0; i < 3; i++) run_line(-1, -1, 3, P, -1, -1);
    chk("R8 two timeouts keep lock", lock_n, 0);
    run_line(-1, -1, 3, P, -1, -1);
    chk("R8 third timeout drops lock", lock_n, 1);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    t_reset();
    t_lock_count();
    t_unlock();
    t_window_run();
    t_unlock_clear();
    t_timeout();
    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule